// File: doc/BRIEF.md
# Selectable Time-Base Interrupt Generator

This block divides a slow source clock with a free-running binary counter and raises a periodic timeout. A three-bit select value picks one counter tap, so the timeout period is any power of two from 2^MIN_EXP to 2^(MIN_EXP+7) source cycles. With the default MIN_EXP of 8, that range is 256 to 32768 cycles. Each timeout sets a sticky request flag. The flag becomes an interrupt request toward a fixed vector only while interrupts are enabled and the return stack has room.

The timeout is also driven out as a one-cycle pulse. A downstream timer can use that pulse as a clock enable, so the two can be chained to reach longer periods. Software loads the select value through a write strobe. Software clears the flag directly, or the flag is cleared by the interrupt acknowledge. Stack fullness comes from outside the block.

Top module: `tbase_irq_gen`

## Requirements
- R1: The time between consecutive timeouts is 2^(MIN_EXP+N) source cycles. N is the select value (bits 2..0 of `selData`, loaded when `selWrite` is high). Code 0 gives the shortest period, and all eight codes are implemented.
- R2: `tickOut` is high for exactly one cycle per timeout. It rises in the cycle in which counter bit MIN_EXP-1+N goes from 0 to 1. The first timeout after reset therefore comes 2^(MIN_EXP+N-1) cycles after reset is released.
- R3: Every timeout sets `flagOut` in the same cycle that `tickOut` is high, whatever the values of `intEnable` and `stackFull`.
- R4: `flagOut` stays set until `flagClear` or `intAck` is sampled high. If a clear and a timeout fall on the same clock edge, the flag remains set.
- R5: `intReq` is high exactly when `flagOut` is high, `intEnable` is high and `stackFull` is low. It follows these inputs in the same cycle.
- R6: `intVector` always carries the fixed call address, 0x18 by default.
- R7: Writing a new select value does not disturb the divider. The next timeout is the next rising edge of the newly selected counter bit.
- R8: Synchronous active-high `rst` clears the counter, the flag and the select value. After reset the block therefore runs with the shortest period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow source clock |
| rst | input | 1 | Synchronous active-high reset |
| selWrite | input | 1 | Load strobe for the period select |
| selData | input | 3 | New period select value N |
| intEnable | input | 1 | Interrupt enable |
| stackFull | input | 1 | Return stack has no free entry |
| flagClear | input | 1 | Software clear of the request flag |
| intAck | input | 1 | Interrupt acknowledge; clears the flag |
| tickOut | output | 1 | One-cycle timeout pulse, also a cascade clock enable |
| flagOut | output | 1 | Sticky timeout request flag |
| intReq | output | 1 | Qualified interrupt request |
| intVector | output | VEC_W | Fixed call address |

## Verification
The bench uses a shortened divider and measures the tick spacing for every select code. A tap mux that is off by one bit shows up there as a doubled or halved period. It changes the select value in the middle of a period and predicts the next tick from the counter value. A design that resets the divider on a write would tick too late. It holds a clear across a timeout edge, where a design that lets clear win would lose the event. It also walks the enable and stack-full inputs against a set flag, so any missing gate term produces a request while the stack is full.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  // Width of the period select field; bits 2..0 of the control word.
  localparam int SEL_W    = 3;
  localparam int NUM_TAPS = 1 << SEL_W;

  // Control-to-datapath strobe bundle.
  typedef struct packed {
    logic [SEL_W-1:0] tapSel;
  } tbase_ctl_t;
endpackage

// File: rtl/tbase_divider.sv
module tbase_divider
  import tbase_pkg::*;
#(
  parameter int MIN_EXP = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  tbase_ctl_t ctl,
  output logic       tapHit,
  output logic       tickOut
);
  localparam int DIV_W = MIN_EXP + NUM_TAPS - 1;

  logic [DIV_W-1:0]    divCnt;
  logic [DIV_W-1:0]    divNext;
  logic [NUM_TAPS-1:0] hitVec;

  assign divNext = divCnt + 1'b1;

  // One rising-edge detector per tap: the tap bit becomes 1 and all lower bits become 0.
  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    localparam int TAP_K = MIN_EXP - 1 + g;
    localparam logic [DIV_W-1:0] LOW_MASK = DIV_W'((64'd1 << (TAP_K + 1)) - 64'd1);
    localparam logic [DIV_W-1:0] TAP_BIT  = DIV_W'(64'd1 << TAP_K);
    assign hitVec[g] = ((divNext & LOW_MASK) == TAP_BIT);
  end

  assign tapHit = hitVec[ctl.tapSel];

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt  <= '0;
      tickOut <= 1'b0;
    end else begin
      divCnt  <= divNext;
      tickOut <= tapHit;
    end
  end

  // Checker state: spacing between hits under one unchanged select value.
  logic [DIV_W:0]   gapCnt;
  logic             gapArmed;
  logic [SEL_W-1:0] selAtHit;

  always_ff @(posedge clk) begin
    if (rst) begin
      gapCnt   <= '0;
      gapArmed <= 1'b0;
      selAtHit <= '0;
    end else begin
      gapCnt <= tapHit ? (DIV_W+1)'(1) : gapCnt + 1'b1;
      if (tapHit) begin
        gapArmed <= 1'b1;
        selAtHit <= ctl.tapSel;
      end
    end
  end

  p_tick_period_r1: assert property (@(posedge clk) disable iff (rst)
    (tapHit && gapArmed && ctl.tapSel == selAtHit) |->
      (gapCnt == ((DIV_W+1)'(1) << (MIN_EXP + int'(ctl.tapSel)))));

  p_tick_single_r2: assert property (@(posedge clk) disable iff (rst)
    tickOut |=> !tickOut);
endmodule

// File: rtl/tbase_ctrl.sv
module tbase_ctrl
  import tbase_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             selWrite,
  input  logic [SEL_W-1:0] selData,
  input  logic             intEnable,
  input  logic             stackFull,
  input  logic             flagClear,
  input  logic             intAck,
  input  logic             tapHit,
  output tbase_ctl_t       ctl,
  output logic             flagOut,
  output logic             intReq
);
  logic [SEL_W-1:0] selQ;
  logic             flagQ;
  logic             clrReq;

  assign clrReq = flagClear | intAck;

  always_ff @(posedge clk) begin
    if (rst) begin
      selQ  <= '0;
      flagQ <= 1'b0;
    end else begin
      if (selWrite) selQ <= selData;
      // A new timeout outranks a clear on the same edge.
      flagQ <= tapHit | (flagQ & ~clrReq);
    end
  end

  assign ctl.tapSel = selQ;
  assign flagOut    = flagQ;
  assign intReq     = flagQ & intEnable & ~stackFull;

  p_flag_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (flagQ && !clrReq) |=> flagQ);

  p_flag_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (clrReq && !tapHit) |=> !flagQ);

  p_sel_kept_r7: assert property (@(posedge clk) disable iff (rst)
    !selWrite |=> $stable(selQ));
endmodule

// File: rtl/tbase_irq_gen.sv
module tbase_irq_gen
  import tbase_pkg::*;
#(
  parameter int          MIN_EXP = 8,
  parameter int          VEC_W   = 8,
  parameter logic [VEC_W-1:0] VECTOR = VEC_W'(8'h18)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             selWrite,
  input  logic [SEL_W-1:0] selData,
  input  logic             intEnable,
  input  logic             stackFull,
  input  logic             flagClear,
  input  logic             intAck,
  output logic             tickOut,
  output logic             flagOut,
  output logic             intReq,
  output logic [VEC_W-1:0] intVector
);
  tbase_ctl_t ctl;
  logic       tapHit;

  tbase_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .selWrite  (selWrite),
    .selData   (selData),
    .intEnable (intEnable),
    .stackFull (stackFull),
    .flagClear (flagClear),
    .intAck    (intAck),
    .tapHit    (tapHit),
    .ctl       (ctl),
    .flagOut   (flagOut),
    .intReq    (intReq)
  );

  tbase_divider #(.MIN_EXP(MIN_EXP)) u_div (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .tapHit  (tapHit),
    .tickOut (tickOut)
  );

  assign intVector = VECTOR;

  p_tick_sets_flag_r3: assert property (@(posedge clk) disable iff (rst)
    tickOut |-> flagOut);

  p_no_req_when_full_r5: assert property (@(posedge clk) disable iff (rst)
    stackFull |-> !intReq);
endmodule

// File: tb/tbase_irq_gen_test.sv
module tbase_irq_gen_test;
  localparam int ME = 2;
  localparam int NT = 8;
  localparam int DW = ME + NT - 1;
  localparam int CW = 1 << DW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic selWrite = 1'b0;
  logic [2:0] selData = '0;
  logic intEnable = 1'b0;
  logic stackFull = 1'b0;
  logic flagClear = 1'b0;
  logic intAck = 1'b0;
  logic tickOut, flagOut, intReq;
  logic [7:0] intVector;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tbase_irq_gen #(.MIN_EXP(ME)) uut (
    .clk(clk), .rst(rst), .selWrite(selWrite), .selData(selData),
    .intEnable(intEnable), .stackFull(stackFull), .flagClear(flagClear),
    .intAck(intAck), .tickOut(tickOut), .flagOut(flagOut),
    .intReq(intReq), .intVector(intVector)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic endRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  // Arithmetic reference: counter value, select value, expected tick and flag.
  int mc;
  logic [2:0] msel;
  logic mflag, mtick;
  always @(posedge clk) begin : mdl
    int k;
    int nx;
    logic h;
    if (rst) begin
      mc <= 0; msel <= '0; mflag <= 1'b0; mtick <= 1'b0;
    end else begin
      k  = ME - 1 + int'(msel);
      nx = (mc + 1) % CW;
      h  = ((nx % (2 << k)) == (1 << k));
      mtick <= h;
      mflag <= h | (mflag & !(flagClear | intAck));
      mc <= nx;
      if (selWrite) msel <= selData;
    end
  end

  // Continuous comparison, sampled away from the active edge.
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R2/R7 tick", int'(tickOut), int'(mtick));
      chk("R3/R4 flag", int'(flagOut), int'(mflag));
      chk("R5 intReq", int'(intReq), int'(mflag & intEnable & !stackFull));
    end
  end

  task automatic waitTick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tickOut && n < 5000);
  endtask

  task automatic writeSel(input int s);
    selWrite = 1'b1;
    selData = 3'(s);
    @(negedge clk);
    selWrite = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    endRun();
  end

  initial begin
    int n;
    int c;
    int v;
    repeat (3) @(negedge clk);
    chk("R8 reset tick", int'(tickOut), 0);
    chk("R8 reset flag", int'(flagOut), 0);
    chk("R8 reset req", int'(intReq), 0);
    chk("R6 vector", int'(intVector), 24);
    rst = 1'b0;

    // First timeout after reset: half the shortest period (R2, R8).
    waitTick(n);
    chk("R2 first tick delay", n, 1 << (ME - 1));
    waitTick(n);
    chk("R8 reset select period", n, 1 << ME);

    // Period sweep over all select codes with varied gating (R1, R5).
    for (int s = 0; s < NT; s++) begin
      intEnable = s[0];
      stackFull = s[1];
      writeSel(s);
      waitTick(n);
      waitTick(n);
      chk($sformatf("R1 period code %0d", s), n, 1 << (ME + s));
      chk("R3 flag on tick", int'(flagOut), 1);
    end

    // Flag set regardless of enable; request gated (R3, R5).
    writeSel(7);
    flagClear = 1'b1; @(negedge clk); flagClear = 1'b0;
    intEnable = 1'b0; stackFull = 1'b0;
    waitTick(n);
    chk("R3 flag while disabled", int'(flagOut), 1);
    chk("R5 req disabled", int'(intReq), 0);
    intEnable = 1'b1; #1;
    chk("R5 req enabled", int'(intReq), 1);
    stackFull = 1'b1; #1;
    chk("R5 req stack full", int'(intReq), 0);
    stackFull = 1'b0;
    repeat (20) @(negedge clk);
    chk("R4 flag sticky", int'(flagOut), 1);
    intAck = 1'b1; @(negedge clk); intAck = 1'b0;
    chk("R4 ack clears", int'(flagOut), 0);
    chk("R5 req after ack", int'(intReq), 0);

    // Clear held across a timeout edge: set wins (R4).
    writeSel(1);
    flagClear = 1'b1;
    waitTick(n);
    chk("R4 set beats clear", int'(flagOut), 1);
    @(negedge clk);
    chk("R4 clear after tick", int'(flagOut), 0);
    flagClear = 1'b0;

    // Select change mid-period does not restart the divider (R7).
    writeSel(7);
    waitTick(n);
    repeat (10) @(negedge clk);
    writeSel(0);
    c = mc;
    v = c;
    do v++; while ((v % (1 << ME)) != (1 << (ME - 1)));
    waitTick(n);
    chk("R7 next tick after select change", n, v - c);
    waitTick(n);
    chk("R7 period after select change", n, 1 << ME);

    // Reset mid-run restores divider, flag and select (R8).
    writeSel(5);
    waitTick(n);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R8 reset clears flag", int'(flagOut), 0);
    rst = 1'b0;
    waitTick(n);
    chk("R8 divider restarted", n, 1 << (ME - 1));
    waitTick(n);
    chk("R8 select cleared", n, 1 << ME);

    repeat (4) @(negedge clk);
    endRun();
  end
endmodule